// File: doc/BRIEF.md
# SPI Flash Instruction Shifter

This block sends one arbitrary instruction to a serial NOR flash over a single-data-line SPI link and keeps whatever the flash returns. Software fills a small register window: six program bytes that hold the opcode and any outgoing bytes, a frame length counted in bits, and a command register that launches the frame. The whole frame (opcode, transmit bytes and receive bytes) runs inside one chip-select assertion. Data is shifted most significant bit first, in SPI mode 0.

The opcode sits in program byte 5. Outgoing bytes follow in bytes 4, 3 and downward, and software clears the program bytes it does not use. Every bit seen on MISO moves into a ten-byte capture chain. When the frame ends, the first received byte is at capture index rxlen-1 and the last received byte is at index 0. The engine also has two fixed shortcuts:
- A status-read command sends a fixed opcode and keeps one returned byte in a separate status register.
- A status-write command shifts out the eight bits held in program byte 5.

Each launched command keeps its bit set in the command register while the frame runs. Software polls that register until it reads zero.

Top module: `spi_cmd_shifter`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0 and mosi_o is 0. The command register (address 0x00) and the status register (address 0x02) both read 0.
- R2: Writing a value with bit 2 set (0x04) to the command register, with the bit-count register (address 0x01) holding N in 1..56, runs exactly N SCK pulses inside one chip-select low period. The command register reads 0x04 while the frame runs and 0 once it has finished.
- R3: MOSI sends program byte 5 (address 0x0D) bit 7 first. It then continues through program byte 0 (address 0x08) bit 0, and drives 0 for any bit beyond the 48th.
- R4: MISO is sampled on each rising SCK edge and shifted into an 80-bit capture chain that is cleared when a frame starts. Capture byte i is read at address 0x10+i. Byte 0 holds the last eight sampled bits, with the latest bit in bit 0.
- R5: Writing bit 1 (0x02) runs a 16-clock frame. The first eight MOSI bits are the opcode parameter (default 0x05) and the rest are 0. MISO bits 9 to 16 land in the status register. The command register reads 0x02 while this frame runs.
- R6: Writing bit 5 (0x20) runs an 8-clock frame that shifts out program byte 5. It ignores the bit-count register.
- R7: A command write while a frame is running is ignored. The running frame keeps its clock count and the status register is not touched.
- R8: A write of 0x04 is ignored when the bit count is 0 or above 56. No chip select occurs and the command register stays 0.
- R9: When several command bits are written together, bit 1 wins over bit 2, and bit 2 wins over bit 5. A write with none of bits 1, 2 or 5 set is ignored.
- R10: Chip select falls DIV_HALF system clocks before the first SCK rise. MOSI never changes while SCK is high.
- R11: The program bytes and the bit-count register read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| sck_o | output | 1 | SPI clock |
| cs_no | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The bench builds the block with DIV_HALF = 3, so every SCK half period lasts several system clocks. This makes the chip-select lead time and the hold of MOSI while SCK is high measurable, instead of collapsing into single-cycle toggles. Because the opcode parameter keeps its default of 0x05, the status-read opcode seen on the line can be compared against a known value. The random frames sweep lengths from 1 to the full 56 bits, which reaches both the point where transmit data runs out and the partial filling of the capture chain.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'h00;
  localparam logic [ADDR_W-1:0] A_BITS = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h02;
  localparam int A_PROG = 8;
  localparam int A_CAP  = 16;

  localparam int B_RDSR = 1;
  localparam int B_GEN  = 2;
  localparam int B_WRSR = 5;

  typedef enum logic [1:0] {K_GEN, K_RDSR, K_WRSR} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_HIGH, S_LOW, S_TRAIL} state_e;
endpackage

// File: rtl/spi_cmd_tick.sv
module spi_cmd_tick #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV_HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int PROG_BYTES = 6,
  parameter int CAP_BYTES  = 10,
  parameter int MAX_BITS   = 56
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic                    busy_i,
  input  logic                    done_i,
  input  logic [8*CAP_BYTES-1:0]  cap_i,
  input  logic [7:0]              stat_i,
  output logic                    start_o,
  output kind_e                   kind_o,
  output logic [7:0]              bits_o,
  output logic [8*PROG_BYTES-1:0] prog_o
);
  logic [7:0] cmd_q, bits_q;
  logic [7:0] prog_q [PROG_BYTES];
  logic wr_cmd, idle, len_ok;

  assign wr_cmd = we_i && (addr_i == A_CMD);
  assign idle   = (cmd_q == '0) && !busy_i;
  assign len_ok = (bits_q != '0) && (bits_q <= 8'(MAX_BITS));
  assign bits_o = bits_q;

  always_comb begin
    kind_o  = K_GEN;
    start_o = 1'b0;
    if (wr_cmd && idle) begin
      if (wdata_i[B_RDSR]) begin
        kind_o = K_RDSR; start_o = 1'b1;
      end else if (wdata_i[B_GEN]) begin
        kind_o = K_GEN;  start_o = len_ok;
      end else if (wdata_i[B_WRSR]) begin
        kind_o = K_WRSR; start_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      bits_q <= '0;
    end else begin
      if (done_i) cmd_q <= '0;
      else if (start_o) begin
        case (kind_o)
          K_RDSR:  cmd_q <= 8'(1) << B_RDSR;
          K_WRSR:  cmd_q <= 8'(1) << B_WRSR;
          default: cmd_q <= 8'(1) << B_GEN;
        endcase
      end
      if (we_i && addr_i == A_BITS) bits_q <= wdata_i;
    end
  end

  for (genvar i = 0; i < PROG_BYTES; i++) begin : g_prog
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prog_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(A_PROG + i)) prog_q[i] <= wdata_i;
    end
    assign prog_o[8*i +: 8] = prog_q[i];
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CMD)  rdata_o = cmd_q;
    if (addr_i == A_BITS) rdata_o = bits_q;
    if (addr_i == A_STAT) rdata_o = stat_i;
    for (int i = 0; i < PROG_BYTES; i++)
      if (addr_i == ADDR_W'(A_PROG + i)) rdata_o = prog_q[i];
    for (int i = 0; i < CAP_BYTES; i++)
      if (addr_i == ADDR_W'(A_CAP + i)) rdata_o = cap_i[8*i +: 8];
  end

  assert_one_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q));
  assert_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !busy_i);
  assert_len_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && kind_o == K_GEN) |-> (bits_q != 8'd0 && bits_q <= 8'(MAX_BITS)));
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int          PROG_W  = 48,
  parameter int          CAP_W   = 80,
  parameter logic [7:0]  RDSR_OP = 8'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  kind_e             kind_i,
  input  logic [7:0]        bits_i,
  input  logic [PROG_W-1:0] prog_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  output logic [CAP_W-1:0]  cap_o,
  output logic [7:0]        stat_o
);
  state_e state_q;
  kind_e  kind_q;
  logic [PROG_W-1:0] tx_q, tx_init;
  logic [7:0] left_q, len;

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_TRAIL) && tick_i;
  assign tx_init = (kind_i == K_RDSR) ? {RDSR_OP, {(PROG_W-8){1'b0}}} : prog_i;

  always_comb begin
    case (kind_i)
      K_RDSR:  len = 8'd16;
      K_WRSR:  len = 8'd8;
      default: len = bits_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_GEN;
      tx_q    <= '0;
      left_q  <= '0;
      sck_o   <= 1'b0;
      cs_no   <= 1'b1;
      mosi_o  <= 1'b0;
      cap_o   <= '0;
      stat_o  <= '0;
    end else if (start_i) begin
      state_q <= S_LEAD;
      kind_q  <= kind_i;
      tx_q    <= tx_init;
      left_q  <= len;
      cs_no   <= 1'b0;
      sck_o   <= 1'b0;
      mosi_o  <= tx_init[PROG_W-1];
      cap_o   <= '0;
    end else if (tick_i) begin
      case (state_q)
        S_LEAD, S_LOW: begin
          sck_o   <= 1'b1;
          cap_o   <= {cap_o[CAP_W-2:0], miso_i};
          state_q <= S_HIGH;
        end
        S_HIGH: begin
          sck_o  <= 1'b0;
          left_q <= left_q - 1'b1;
          if (left_q == 8'd1) begin
            mosi_o  <= 1'b0;
            state_q <= S_TRAIL;
          end else begin
            tx_q    <= tx_q << 1;
            mosi_o  <= tx_q[PROG_W-2];
            state_q <= S_LOW;
          end
        end
        S_TRAIL: begin
          cs_no   <= 1'b1;
          state_q <= S_IDLE;
          if (kind_q == K_RDSR) stat_o <= cap_o[7:0];
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_idle_lines_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sck_o));
  assert_sck_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sck_o) |-> !cs_no);
  assert_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (cs_no && !busy_o));
  assert_mosi_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |=> (!sck_o || $stable(mosi_o)));
  assert_no_extra_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (state_q == S_LEAD || state_q == S_LOW)) |-> (left_q != 8'd0));
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter int         DIV_HALF   = 2,
  parameter int         PROG_BYTES = 6,
  parameter int         CAP_BYTES  = 10,
  parameter logic [7:0] RDSR_OP    = 8'h05
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int PROG_W   = 8 * PROG_BYTES;
  localparam int CAP_W    = 8 * CAP_BYTES;
  localparam int MAX_BITS = 8 * (PROG_BYTES + 1);

  logic start, busy, done, tick;
  kind_e kind;
  logic [7:0] bits, stat;
  logic [PROG_W-1:0] prog;
  logic [CAP_W-1:0] cap;

  spi_cmd_regs #(
    .PROG_BYTES(PROG_BYTES), .CAP_BYTES(CAP_BYTES), .MAX_BITS(MAX_BITS)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .cap_i(cap), .stat_i(stat),
    .start_o(start), .kind_o(kind), .bits_o(bits), .prog_o(prog)
  );

  spi_cmd_tick #(.DIV_HALF(DIV_HALF)) u_tick (
    .clk_i, .rst_ni, .run_i(busy), .tick_o(tick)
  );

  spi_cmd_engine #(.PROG_W(PROG_W), .CAP_W(CAP_W), .RDSR_OP(RDSR_OP)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .kind_i(kind), .bits_i(bits), .prog_i(prog), .tick_i(tick),
    .miso_i, .busy_o(busy), .done_o(done),
    .sck_o, .cs_no, .mosi_o, .cap_o(cap), .stat_o(stat)
  );
endmodule

// File: tb/tb_spi_cmd_shifter.sv
module tb_spi_cmd_shifter;
  localparam int DIV_HALF = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sck, cs_n, mosi;
  logic miso = 1'b0;

  int nchk = 0, nfail = 0, cyc = 0;
  int nbits = 0, idx = 0, cs_falls = 0, t_cs = 0, t_rise = 0;
  logic [55:0] mosi_rx = '0, resp = '0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_cmd_shifter #(.DIV_HALF(DIV_HALF)) dut (
    .clk_i(clk), .rst_ni, .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  // flash model: mode 0, output on falling SCK
  always @(negedge cs_n) begin
    nbits = 0; idx = 0; mosi_rx = '0; miso = resp[55]; t_cs = cyc; cs_falls++;
  end
  always @(posedge sck) if (!cs_n) begin
    if (nbits == 0) t_rise = cyc;
    mosi_rx = {mosi_rx[54:0], mosi};
    nbits++;
  end
  always @(negedge sck) if (!cs_n) begin
    idx++;
    miso = (idx < 56) ? resp[55-idx] : 1'b0;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(5'h00, v);
      if (v == 8'h00) return;
    end
  endtask

  function automatic logic [55:0] exp_mosi(logic [47:0] p, int n);
    logic [55:0] s = {p, 8'h00};
    return s >> (56 - n);
  endfunction

  function automatic logic [79:0] exp_cap(logic [55:0] r, int n);
    logic [79:0] c = '0;
    for (int k = 0; k < n; k++) c = {c[78:0], r[55-k]};
    return c;
  endfunction

  task automatic load_prog(logic [47:0] p);
    for (int i = 0; i < 6; i++) wr(5'(8 + i), p[8*i +: 8]);
  endtask

  task automatic run_gen(int n, logic [47:0] p, logic [55:0] r);
    logic [7:0] v;
    logic [79:0] c;
    load_prog(p);
    wr(5'h01, 8'(n));
    resp = r;
    wr(5'h00, 8'h04);
    wait_idle();
    chk("R2 sck count", 80'(nbits), 80'(n));
    chk("R3 mosi stream", 80'(mosi_rx), 80'(exp_mosi(p, n)));
    chk("R10 cs lead", 80'(t_rise - t_cs), 80'(DIV_HALF));
    c = exp_cap(r, n);
    for (int i = 0; i < 10; i++) begin
      rd(5'(16 + i), v);
      chk("R4 capture byte", 80'(v), 80'(c[8*i +: 8]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [47:0] p;
    logic [55:0] r;
    int falls;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs idle", 80'(cs_n), 80'(1));
    chk("R1 sck idle", 80'(sck), 80'(0));
    chk("R1 mosi idle", 80'(mosi), 80'(0));
    rst_ni = 1'b1;
    rd(5'h00, v); chk("R1 cmd reset", 80'(v), 80'(0));
    rd(5'h02, v); chk("R1 status reset", 80'(v), 80'(0));

    // R11 readback
    wr(5'h0d, 8'h3c); rd(5'h0d, v); chk("R11 prog5 readback", 80'(v), 80'(8'h3c));
    wr(5'h01, 8'd40); rd(5'h01, v); chk("R11 bitcount readback", 80'(v), 80'(40));

    // directed: minimal, boundary and full frames
    run_gen(1, 48'h80_0000_0000_00, 56'h80_0000_0000_0000);
    run_gen(8, 48'h9f_0000_0000_00, 56'hff_ffff_ffff_ffff);
    run_gen(56, 48'hab_cdef_0123_45, 56'h01_2345_6789_abcd);

    // R2 busy visible mid-frame
    load_prog(48'h05_0000_0000_00); wr(5'h01, 8'd32); resp = '1;
    wr(5'h00, 8'h04);
    rd(5'h00, v); chk("R2 busy bit", 80'(v), 80'(8'h04));
    // R7 second command while busy is ignored
    wr(5'h00, 8'h02);
    rd(5'h00, v); chk("R7 busy unchanged", 80'(v), 80'(8'h04));
    wait_idle();
    chk("R7 clock count kept", 80'(nbits), 80'(32));
    rd(5'h02, v); chk("R7 status untouched", 80'(v), 80'(0));

    // R5 status read
    resp = 56'h00_c3_0000_0000_00;
    wr(5'h00, 8'h02);
    rd(5'h00, v); chk("R5 busy bit", 80'(v), 80'(8'h02));
    wait_idle();
    chk("R5 clock count", 80'(nbits), 80'(16));
    chk("R5 opcode on mosi", 80'(mosi_rx[15:0]), 80'(16'h0500));
    rd(5'h02, v); chk("R5 status byte", 80'(v), 80'(8'hc3));

    // R6 status write ignores bit count
    wr(5'h0d, 8'ha5); wr(5'h01, 8'd48);
    wr(5'h00, 8'h20);
    wait_idle();
    chk("R6 clock count", 80'(nbits), 80'(8));
    chk("R6 mosi byte", 80'(mosi_rx[7:0]), 80'(8'ha5));

    // R8 illegal lengths
    falls = cs_falls;
    wr(5'h01, 8'd0); wr(5'h00, 8'h04);
    rd(5'h00, v); chk("R8 zero length ignored", 80'(v), 80'(0));
    wr(5'h01, 8'd57); wr(5'h00, 8'h04);
    rd(5'h00, v); chk("R8 long length ignored", 80'(v), 80'(0));
    repeat (20) @(negedge clk);
    chk("R8 no chip select", 80'(cs_falls), 80'(falls));

    // R9 priority and ignored values
    wr(5'h00, 8'h01);
    rd(5'h00, v); chk("R9 no command bit", 80'(v), 80'(0));
    repeat (10) @(negedge clk);
    chk("R9 no frame", 80'(cs_falls), 80'(falls));
    resp = '0;
    wr(5'h01, 8'd8); wr(5'h00, 8'h26);
    rd(5'h00, v); chk("R9 status read wins", 80'(v), 80'(8'h02));
    wait_idle();
    chk("R9 status read length", 80'(nbits), 80'(16));
    wr(5'h0d, 8'h77); wr(5'h01, 8'd24); wr(5'h00, 8'h24);
    rd(5'h00, v); chk("R9 generic beats write", 80'(v), 80'(8'h04));
    wait_idle();
    chk("R9 generic length", 80'(nbits), 80'(24));

    // constrained random frames
    for (int t = 0; t < 20; t++) begin
      int n = 1 + int'($urandom_range(55));
      p = {$urandom(), 16'($urandom())};
      r = {$urandom(), 24'($urandom())};
      run_gen(n, p, r);
    end

    summary();
    $finish;
  end
endmodule